// File: doc/BRIEF.md
# Fractional Bit-Clock Divider with Frame Sync

This block derives a slow audio bit clock from a much faster system clock when the ratio between the two is not a whole number. A system clock of 120 MHz and a 256 kHz target give a ratio of 468.75. No single integer counter can produce that ratio. The block therefore makes each output period either N or N+1 system cycles long. A phase accumulator picks the length again at every period boundary, so the long-run average equals N plus the fraction. Each output edge sits within one system-clock period of its ideal position.

The integer part `div_int` and a 16-bit fraction `div_frac` (value F/65536) set the ratio. When the fraction is zero the block is a plain divider with no jitter. An example is 96 MHz divided by 375. Alongside the bit clock the block gives a one-cycle pulse on each bit-clock rising edge. It also gives a frame pulse once every 32 bit clocks, which turns 256 kHz into an 8 kHz frame rate. Ratio inputs are sampled only at period boundaries. They can therefore be rewritten while the block runs.

Top module: `frac_clk_div`

## Requirements
- R1: Every output period, measured between consecutive `bclk_rise` pulses, lasts either N or N+1 cycles. N is `div_int`.
- R2: Over the first K periods after enable, the total cycle count is exactly K*N + floor(K*F/65536). This is within one cycle of the ideal K*(N+F/65536).
- R3: The accumulator starts at zero on enable and adds F at each boundary. A period is N+1 long only when that addition carries past 65535, so the first period is always N long. For N=23 and F=0xC000 the lengths run 23, 24, 24, 24 and then repeat.
- R4: In each period of length P, `bclk` is high for the first floor(P/2) cycles and low for the rest. `bclk_rise` is high for exactly the first cycle of each period. Periods follow one another with no idle cycle.
- R5: `fsync` is a one-cycle pulse that appears only together with `bclk_rise`. It appears on the first period after enable and on every 32nd period after that.
- R6: With F=0 every period is exactly N cycles long.
- R7: A change to `div_int` or `div_frac` does not alter the period in progress. It takes effect from the next period boundary.
- R8: While `rst` is high or `en` is low, the counters and the accumulator are cleared and all three outputs are low. This holds from the cycle after that condition is sampled. The first `bclk_rise` comes in the cycle after `en` is first sampled high.
- R9: A `div_int` value of 0 or 1 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears and idles the block |
| div_int | input | IW (16) | Integer part N of the divide ratio |
| div_frac | input | FW (16) | Fractional part F of the ratio, in units of 1/2^FW |
| bclk | output | 1 | Divided bit clock |
| bclk_rise | output | 1 | One-cycle pulse in the first cycle of each bit-clock period |
| fsync | output | 1 | One-cycle frame pulse every FRAME_LEN (32) bit clocks |

## Verification
A corrupted accumulator does not change any single period's legality. It moves the point where a long period lands in the sequence, so the scoreboard sees a wrong length within a few periods of the fault. The long-run total catches any lost or extra carry over the 4096-period run. A fault in the period counter shows at once as a period of the wrong length or a wrong high-time. A fault in the frame counter shows as a missing or misplaced `fsync` within 32 bit clocks.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned cnt_width(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction
endpackage

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
   parameter int FW = 16
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          step,
   input  logic [FW-1:0] frac,
   output logic          carry
);
   logic [FW-1:0] acc;
   logic [FW:0]   sum;

   assign sum   = {1'b0, acc} + {1'b0, frac};
   assign carry = sum[FW];

   always_ff @(posedge clk) begin
      if (clr)       acc <= '0;
      else if (step) acc <= sum[FW-1:0];
   end

   // R3: a carry step leaves the phase below its previous value
   a_r3_carry_wraps: assert property (@(posedge clk) disable iff (clr)
      (step && carry) |=> (acc < $past(acc)));

   // R3: after clearing, the phase is zero so no carry is possible
   a_r3_clear_zero: assert property (@(posedge clk)
      clr |=> (acc == '0));
endmodule

// File: rtl/frac_period_gen.sv
module frac_period_gen #(
   parameter int LW = 17
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          en,
   input  logic [LW-1:0] load_len,
   output logic          boundary,
   output logic          bclk,
   output logic          bclk_rise
);
   logic          running;
   logic [LW-1:0] cnt;
   logic [LW-1:0] len;
   logic [LW-1:0] half;
   logic [LW-1:0] cnt_inc;

   assign cnt_inc  = cnt + 1'b1;
   assign boundary = en && (!running || (cnt == len - 1'b1));

   always_ff @(posedge clk) begin
      if (clr) begin
         running   <= 1'b0;
         cnt       <= '0;
         len       <= '0;
         half      <= '0;
         bclk      <= 1'b0;
         bclk_rise <= 1'b0;
      end else if (boundary) begin
         running   <= 1'b1;
         cnt       <= '0;
         len       <= load_len;
         half      <= load_len >> 1;
         bclk      <= 1'b1;
         bclk_rise <= 1'b1;
      end else if (running) begin
         cnt       <= cnt_inc;
         bclk      <= (cnt_inc < half);
         bclk_rise <= 1'b0;
      end
   end

   // R4: inside a period the count advances by one every cycle
   a_r4_contiguous: assert property (@(posedge clk) disable iff (clr)
      (running && !boundary) |=> (cnt == $past(cnt) + 1'b1));

   // R4: the rise pulse always lands on a high bit clock
   a_r4_rise_high: assert property (@(posedge clk) disable iff (clr)
      bclk_rise |-> bclk);

   // R4: a pulse never lasts two cycles, since every period has at least 2 cycles
   a_r4_rise_single: assert property (@(posedge clk) disable iff (clr)
      bclk_rise |=> !bclk_rise);
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
   parameter int FRAME_LEN = 32
) (
   input  logic clk,
   input  logic clr,
   input  logic tick,
   output logic fsync
);
   import frac_div_pkg::*;

   localparam int FCW = cnt_width(FRAME_LEN);

   logic [FCW-1:0] fcnt;
   logic [FCW-1:0] fcnt_nxt;

   generate
      if (is_pow2(FRAME_LEN)) begin : g_wrap_natural
         assign fcnt_nxt = fcnt + 1'b1;
      end else begin : g_wrap_compare
         assign fcnt_nxt = (fcnt == FCW'(FRAME_LEN - 1)) ? '0 : fcnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         fcnt  <= '0;
         fsync <= 1'b0;
      end else if (tick) begin
         fcnt  <= fcnt_nxt;
         fsync <= (fcnt == '0);
      end else begin
         fsync <= 1'b0;
      end
   end

   // R5: a tick in mid-frame yields no frame pulse
   a_r5_mid_frame_quiet: assert property (@(posedge clk) disable iff (clr)
      (tick && (fcnt != '0)) |=> !fsync);

   // R5: a frame pulse never lasts two cycles
   a_r5_fsync_single: assert property (@(posedge clk) disable iff (clr)
      fsync |=> !fsync);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
   parameter int IW        = 16,
   parameter int FW        = 16,
   parameter int FRAME_LEN = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [IW-1:0] div_int,
   input  logic [FW-1:0] div_frac,
   output logic          bclk,
   output logic          bclk_rise,
   output logic          fsync
);
   localparam int LW = IW + 1;

   generate
      if (IW < 2) begin : g_bad_iw
         $error("frac_clk_div: IW must be at least 2");
      end
      if (FW < 1) begin : g_bad_fw
         $error("frac_clk_div: FW must be at least 1");
      end
      if (FRAME_LEN < 2) begin : g_bad_frame
         $error("frac_clk_div: FRAME_LEN must be at least 2");
      end
   endgenerate

   logic          clr;
   logic          boundary;
   logic          carry;
   logic [IW-1:0] n_eff;
   logic [LW-1:0] next_len;

   assign clr      = rst || !en;
   assign n_eff    = (div_int < IW'(2)) ? IW'(2) : div_int;
   assign next_len = {1'b0, n_eff} + LW'(carry);

   frac_phase_acc #(.FW(FW)) u_acc (
      .clk   (clk),
      .clr   (clr),
      .step  (boundary),
      .frac  (div_frac),
      .carry (carry)
   );

   frac_period_gen #(.LW(LW)) u_per (
      .clk       (clk),
      .clr       (clr),
      .en        (en),
      .load_len  (next_len),
      .boundary  (boundary),
      .bclk      (bclk),
      .bclk_rise (bclk_rise)
   );

   frame_sync_gen #(.FRAME_LEN(FRAME_LEN)) u_frm (
      .clk   (clk),
      .clr   (clr),
      .tick  (boundary),
      .fsync (fsync)
   );

   // R1, R9: the loaded length is the clamped integer part or one more than it
   a_r1_len_range: assert property (@(posedge clk) disable iff (clr)
      boundary |-> ((next_len == {1'b0, n_eff}) || (next_len == {1'b0, n_eff} + 1'b1)));

   // R9: the clamped integer part is never below 2
   a_r9_min_two: assert property (@(posedge clk) disable iff (rst)
      en |-> (n_eff >= IW'(2)));

   // R5: a frame pulse only comes with a period start
   a_r5_fsync_on_rise: assert property (@(posedge clk) disable iff (rst)
      fsync |-> bclk_rise);

   // R8: once disabled, every output is low
   a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!bclk && !bclk_rise && !fsync));
endmodule

// File: tb/sim_frac_clk_div.sv
`timescale 1ns/1ps
module sim_frac_clk_div;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic [15:0] div_int = 16'd0;
   logic [15:0] div_frac = 16'd0;
   logic        bclk, bclk_rise, fsync;

   always #2.5 clk = ~clk;

   frac_clk_div u0 (
      .clk(clk), .rst(rst), .en(en), .div_int(div_int), .div_frac(div_frac),
      .bclk(bclk), .bclk_rise(bclk_rise), .fsync(fsync)
   );

   typedef struct { int len; bit fs; } item_t;
   item_t q[$];

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   string cur_req = "R1";

   // reference model state
   bit m_run = 0;
   int m_cnt = 0, m_len = 0, m_acc = 0, m_frame = 0;

   // monitor state and logs
   bit   have_cur = 0;
   item_t cur;
   int   cyc = 0, high = 0;
   int   lens[$];
   longint sum_first = 0;
   int   nper = 0, nrise = 0, nfs = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic step();
      @(posedge clk);
      if (rst || !en) begin
         m_run = 0; m_acc = 0; m_frame = 0; m_cnt = 0;
      end else if (!m_run || m_cnt == m_len - 1) begin
         int n, s;
         n = (div_int < 2) ? 2 : int'(div_int);
         s = m_acc + int'(div_frac);
         m_len = n + ((s >= 65536) ? 1 : 0);
         m_acc = s % 65536;
         q.push_back('{m_len, (m_frame == 0)});
         m_frame = (m_frame + 1) % 32;
         m_cnt = 0;
         m_run = 1;
      end else begin
         m_cnt++;
      end
      #1;
   endtask

   task automatic clear_logs();
      lens.delete();
      sum_first = 0; nper = 0; nrise = 0; nfs = 0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (bclk_rise) begin
            if (have_cur) begin
               chk(cyc == cur.len, {cur_req, " period length"}, cyc, cur.len);
               chk(high == cur.len / 2, "R4 high time", high, cur.len / 2);
               lens.push_back(cyc);
               if (nper < 4096) sum_first += cyc;
               nper++;
            end
            nrise++;
            if (fsync) nfs++;
            if (q.size() == 0) begin
               chk(1'b0, "R4 unexpected rise", 1, 0);
               have_cur = 0;
            end else begin
               cur = q.pop_front();
               chk(fsync == cur.fs, "R5 fsync at rise", fsync, cur.fs);
               have_cur = 1;
               cyc = 1;
               high = bclk ? 1 : 0;
            end
         end else begin
            if (fsync) chk(1'b0, "R5 fsync without rise", 1, 0);
            if (have_cur) begin
               cyc++;
               if (bclk) high++;
            end
         end
         if (!en) begin
            have_cur = 0;
            q.delete();
         end
      end
   end

   initial begin
      #(200000 * 5.0);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (4) step();
      @(negedge clk);
      chk({bclk, bclk_rise, fsync} == 3'b000, "R8 reset outputs", {bclk, bclk_rise, fsync}, 0);
      @(posedge clk); #1;
      rst = 1'b0;
      repeat (2) step();

      // fractional ratio 23.75 over 4096 periods
      cur_req = "R1"; clear_logs();
      div_int = 16'd23; div_frac = 16'hC000; en = 1'b1;
      step();
      @(negedge clk);
      chk(bclk_rise == 1'b1, "R8 first rise after enable", bclk_rise, 1);
      while (nper < 4096) step();
      chk(lens[0] == 23 && lens[1] == 24 && lens[2] == 24 && lens[3] == 24,
          "R3 pattern start", lens[0], 23);
      chk(lens[4] == 23 && lens[7] == 24, "R3 pattern repeat", lens[4], 23);
      chk(sum_first == 64'd97280, "R2 total over 4096 periods", sum_first, 97280);
      chk((sum_first - 97280 <= 1) && (97280 - sum_first <= 1), "R2 within one cycle",
          sum_first, 97280);
      chk(nfs == (nrise + 31) / 32, "R5 frame pulse count", nfs, (nrise + 31) / 32);

      // disable mid-run
      step(); step(); step();
      en = 1'b0;
      step();
      @(negedge clk);
      chk({bclk, bclk_rise, fsync} == 3'b000, "R8 disabled outputs", {bclk, bclk_rise, fsync}, 0);
      repeat (5) step();
      chk({bclk, bclk_rise, fsync} == 3'b000, "R8 stays idle", {bclk, bclk_rise, fsync}, 0);

      // integer ratio
      cur_req = "R6"; clear_logs();
      div_int = 16'd15; div_frac = 16'h0000; en = 1'b1;
      step();
      @(negedge clk);
      chk(fsync == 1'b1, "R5 fsync on first period after re-enable", fsync, 1);
      while (nper < 200) step();
      begin
         int bad = 0;
         foreach (lens[i]) if (lens[i] != 15) bad++;
         chk(bad == 0, "R6 zero jitter", bad, 0);
      end
      en = 1'b0; step(); step();

      // ratio change in mid-period
      cur_req = "R7"; clear_logs();
      div_int = 16'd10; div_frac = 16'h4000; en = 1'b1;
      repeat (25) step();
      div_int = 16'd17; div_frac = 16'h0000;
      while (nper < 8) step();
      chk(lens[1] == 10 && lens[2] == 10, "R7 period in progress keeps old length", lens[2], 10);
      chk(lens[4] == 17, "R7 new length after boundary", lens[4], 17);
      en = 1'b0; step(); step();

      // clamp of tiny integer part
      cur_req = "R9"; clear_logs();
      div_int = 16'd1; div_frac = 16'h8000; en = 1'b1;
      while (nper < 6) step();
      chk(lens[0] == 2 && lens[1] == 3, "R9 one treated as two", lens[0], 2);
      en = 1'b0; step(); step();
      clear_logs();
      div_int = 16'd0; div_frac = 16'h0000; en = 1'b1;
      while (nper < 6) step();
      chk(lens[0] == 2 && lens[5] == 2, "R9 zero treated as two", lens[0], 2);
      en = 1'b0; step(); step();

      finish_run();
   end
endmodule